// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control unit of a small accumulator machine. It steps every instruction through a fetch cycle and, when the instruction asks for it, an indirect cycle. It then runs an execute cycle and, when an interrupt is pending and allowed, an interrupt cycle. It owns the program counter, the memory address register, the memory buffer register, the instruction register, the accumulator and the interrupt-enable flag. On every clock it drives the transfer strobes that move values between them. All memory traffic goes through one request port.

The memory port follows valid/ready rules. `mem_req` is the valid. While it is high and `mem_ready` is low, the sequencer holds `mem_addr`, `mem_we` and `mem_wdata` unchanged and does not leave its state. A transfer happens on a clock edge where both are high, and the sequencer then drops the request for at least one cycle. `mem_ready` has no effect while `mem_req` is low. Memory may therefore stall any access for any number of cycles.

Instruction word (DATA_W = ADDR_W + 4 bits): bit DATA_W-1 is the indirect flag, bits DATA_W-2..ADDR_W hold a 3-bit opcode, and bits ADDR_W-1..0 hold the address field. The opcodes are 0 load, 1 store, 2 jump, 3 return, 4 enable interrupts, 5 disable interrupts, and 6 and 7 do nothing.

Top module: `icc_seq`

## Requirements
- R1: While `rst_n` is low, `pc` = 0, `acc` = 0, `int_en` = 0, `mem_req` = 0 and `cyc_phase` = 4'b0001. The first access after reset is a read at address 0.
- R2: Each fetch issues one read at the current PC. The returned word ends up in `ir`. The PC becomes the fetch address plus one on the edge that completes the read.
- R3: An access with `mem_req` high and `mem_ready` low keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged on the next cycle.
- R4: For load, store or jump with the indirect flag set, a read at the instruction's address field follows the fetch. The low ADDR_W bits of the returned word are then the effective address. Otherwise the effective address is the address field itself.
- R5: Load reads the effective address into `acc`. Store writes `acc` to the effective address.
- R6: Jump makes the next fetch read the effective address, with no data access in between.
- R7: The interrupt request is only examined when an instruction finishes. It is taken only if `irq` is high and interrupt-enable is 1 after that instruction's own effect on it.
- R8: An interrupt cycle pulses `irq_ack` for exactly one cycle and clears `int_en`. It writes the address of the next instruction to SAVE_ADDR, then reads VEC_ADDR. Fetching resumes at the low ADDR_W bits of that word.
- R9: Return reads SAVE_ADDR, and the next fetch goes to the low ADDR_W bits of that word.
- R10: The indirect flag has no effect on opcodes 3 to 7: no extra read takes place.
- R11: Opcode 4 sets `int_en` and opcode 5 clears it. Neither makes a memory access.
- R12: `cyc_phase` is one-hot: bit 0 fetch, bit 1 indirect, bit 2 execute, bit 3 interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request level |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| int_en | output | 1 | Interrupt-enable flag |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Access address (memory address register) |
| mem_wdata | output | DATA_W | Write data (memory buffer register) |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ready` |
| pc | output | ADDR_W | Program counter |
| acc | output | DATA_W | Accumulator |
| ir | output | DATA_W | Instruction register |
| cyc_phase | output | 4 | One-hot cycle indicator |
| xfer | output | 6 | Load strobes: 0 MAR, 1 MBR, 2 IR, 3 PC, 4 ACC, 5 interrupt-enable |

## Verification
Two things can coincide at the end of an instruction. One is recognition of an interrupt. The other is the instruction's own write to interrupt-enable. With `irq` held high from reset, an enable instruction must be followed straight away by the save/vector sequence. A disable instruction and a return running with the flag clear must not be. The captured access trace is compared entry by entry against a sequence computed in the bench.

The fetch read's completion and the PC increment also share one edge. Each sweep run places the program at consecutive addresses and then checks the address order of the following fetches. These checks run under zero, one and two wait states.

// File: rtl/icc_pkg.sv
package icc_pkg;

  localparam int unsigned OP_W = 3;

  localparam logic [OP_W-1:0] OP_LOAD  = 3'd0;
  localparam logic [OP_W-1:0] OP_STORE = 3'd1;
  localparam logic [OP_W-1:0] OP_JUMP  = 3'd2;
  localparam logic [OP_W-1:0] OP_RET   = 3'd3;
  localparam logic [OP_W-1:0] OP_IEN   = 3'd4;
  localparam logic [OP_W-1:0] OP_IDIS  = 3'd5;

  typedef enum logic [3:0] {
    S_FADR, S_FMEM, S_FIR, S_DEC,
    S_IADR, S_IMEM,
    S_EXE, S_OMEM,
    S_ISAVE, S_IWR, S_IVADR, S_IVRD
  } state_e;

  typedef enum logic [2:0] {MAR_HOLD, MAR_PC, MAR_FIELD, MAR_SAVE, MAR_VEC} mar_src_e;
  typedef enum logic [1:0] {MBR_HOLD, MBR_MEM, MBR_ACC, MBR_PC} mbr_src_e;
  typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_FIELD, PC_MEM} pc_op_e;
  typedef enum logic [1:0] {IE_HOLD, IE_SET, IE_CLR} ie_op_e;

  typedef struct packed {
    mar_src_e mar;
    mbr_src_e mbr;
    logic     ld_ir;
    pc_op_e   pc;
    logic     ld_acc;
    ie_op_e   ie;
  } ctl_t;

endpackage

// File: rtl/icc_datapath.sv
module icc_datapath
  import icc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0},
  parameter logic [ADDR_W-1:0] VEC_ADDR  = {ADDR_W{1'b1}}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctl_t                       ctl_i,
  input  logic [ADDR_W+OP_W:0]       rdata_i,
  output logic [ADDR_W-1:0]          pc_o,
  output logic [ADDR_W-1:0]          mar_o,
  output logic [ADDR_W+OP_W:0]       mbr_o,
  output logic [ADDR_W+OP_W:0]       ir_o,
  output logic [ADDR_W+OP_W:0]       acc_o,
  output logic                       ie_o
);
  localparam int unsigned DATA_W = ADDR_W + OP_W + 1;

  logic [ADDR_W-1:0] field;
  assign field = mbr_o[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o  <= '0;
      mar_o <= '0;
      mbr_o <= '0;
      ir_o  <= '0;
      acc_o <= '0;
      ie_o  <= 1'b0;
    end else begin
      case (ctl_i.mar)
        MAR_PC:    mar_o <= pc_o;
        MAR_FIELD: mar_o <= field;
        MAR_SAVE:  mar_o <= SAVE_ADDR;
        MAR_VEC:   mar_o <= VEC_ADDR;
        default:   ;
      endcase
      case (ctl_i.mbr)
        MBR_MEM: mbr_o <= rdata_i;
        MBR_ACC: mbr_o <= acc_o;
        MBR_PC:  mbr_o <= {{(DATA_W-ADDR_W){1'b0}}, pc_o};
        default: ;
      endcase
      case (ctl_i.pc)
        PC_INC:   pc_o <= pc_o + 1'b1;
        PC_FIELD: pc_o <= field;
        PC_MEM:   pc_o <= rdata_i[ADDR_W-1:0];
        default:  ;
      endcase
      case (ctl_i.ie)
        IE_SET:  ie_o <= 1'b1;
        IE_CLR:  ie_o <= 1'b0;
        default: ;
      endcase
      if (ctl_i.ld_ir)  ir_o  <= mbr_o;
      if (ctl_i.ld_acc) acc_o <= rdata_i;
    end
  end

  // R2: the instruction register only takes a value that already sat in the buffer
  p_ir_from_mbr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i.ld_ir |=> (ir_o == $past(mbr_o)));

endmodule

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import icc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_i,
  input  logic            ind_i,
  input  logic            irq_i,
  input  logic            ie_i,
  input  logic            ready_i,
  output ctl_t            ctl_o,
  output logic            req_o,
  output logic            we_o,
  output logic            ack_o,
  output logic [3:0]      phase_o
);
  state_e state, nxt;
  logic   done, ie_eff, memref;

  assign memref = (op_i == OP_LOAD) || (op_i == OP_STORE) || (op_i == OP_JUMP);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_FADR;
    else        state <= nxt;
  end

  always_comb begin
    nxt          = state;
    ctl_o.mar    = MAR_HOLD;
    ctl_o.mbr    = MBR_HOLD;
    ctl_o.ld_ir  = 1'b0;
    ctl_o.pc     = PC_HOLD;
    ctl_o.ld_acc = 1'b0;
    ctl_o.ie     = IE_HOLD;
    req_o        = 1'b0;
    we_o         = 1'b0;
    ack_o        = 1'b0;
    done         = 1'b0;
    ie_eff       = ie_i;
    case (state)
      S_FADR: begin
        ctl_o.mar = MAR_PC;
        nxt       = S_FMEM;
      end
      S_FMEM: begin
        req_o = 1'b1;
        if (ready_i) begin
          ctl_o.mbr = MBR_MEM;
          ctl_o.pc  = PC_INC;
          nxt       = S_FIR;
        end
      end
      S_FIR: begin
        ctl_o.ld_ir = 1'b1;
        nxt         = S_DEC;
      end
      S_DEC:  nxt = (ind_i && memref) ? S_IADR : S_EXE;
      S_IADR: begin
        ctl_o.mar = MAR_FIELD;
        nxt       = S_IMEM;
      end
      S_IMEM: begin
        req_o = 1'b1;
        if (ready_i) begin
          ctl_o.mbr = MBR_MEM;
          nxt       = S_EXE;
        end
      end
      S_EXE: begin
        case (op_i)
          OP_LOAD: begin
            ctl_o.mar = MAR_FIELD;
            nxt       = S_OMEM;
          end
          OP_STORE: begin
            ctl_o.mar = MAR_FIELD;
            ctl_o.mbr = MBR_ACC;
            nxt       = S_OMEM;
          end
          OP_RET: begin
            ctl_o.mar = MAR_SAVE;
            nxt       = S_OMEM;
          end
          OP_JUMP: begin
            ctl_o.pc = PC_FIELD;
            done     = 1'b1;
          end
          OP_IEN: begin
            ctl_o.ie = IE_SET;
            ie_eff   = 1'b1;
            done     = 1'b1;
          end
          OP_IDIS: begin
            ctl_o.ie = IE_CLR;
            ie_eff   = 1'b0;
            done     = 1'b1;
          end
          default: done = 1'b1;
        endcase
      end
      S_OMEM: begin
        req_o = 1'b1;
        we_o  = (op_i == OP_STORE);
        if (ready_i) begin
          ctl_o.ld_acc = (op_i == OP_LOAD);
          if (op_i == OP_RET) ctl_o.pc = PC_MEM;
          done = 1'b1;
        end
      end
      S_ISAVE: begin
        ctl_o.mar = MAR_SAVE;
        ctl_o.mbr = MBR_PC;
        ctl_o.ie  = IE_CLR;
        ack_o     = 1'b1;
        nxt       = S_IWR;
      end
      S_IWR: begin
        req_o = 1'b1;
        we_o  = 1'b1;
        if (ready_i) nxt = S_IVADR;
      end
      S_IVADR: begin
        ctl_o.mar = MAR_VEC;
        nxt       = S_IVRD;
      end
      S_IVRD: begin
        req_o = 1'b1;
        if (ready_i) begin
          ctl_o.pc = PC_MEM;
          nxt      = S_FADR;
        end
      end
      default: nxt = S_FADR;
    endcase
    if (done) nxt = (irq_i && ie_eff) ? S_ISAVE : S_FADR;
  end

  always_comb begin
    case (state)
      S_IADR, S_IMEM:                   phase_o = 4'b0010;
      S_EXE, S_OMEM:                    phase_o = 4'b0100;
      S_ISAVE, S_IWR, S_IVADR, S_IVRD: phase_o = 4'b1000;
      default:                          phase_o = 4'b0001;
    endcase
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ready_i) |=> (req_o && $stable(we_o) && $stable(state)));

  p_phase_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(phase_o));

  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  p_int_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(irq_i));

endmodule

// File: rtl/icc_seq.sv
module icc_seq
  import icc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SAVE_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0},
  parameter logic [ADDR_W-1:0] VEC_ADDR  = {ADDR_W{1'b1}},
  localparam int unsigned DATA_W = ADDR_W + OP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  output logic              irq_ack,
  output logic              int_en,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] ir,
  output logic [3:0]        cyc_phase,
  output logic [5:0]        xfer
);
  ctl_t ctl;

  icc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (ir[DATA_W-2 -: OP_W]),
    .ind_i   (ir[DATA_W-1]),
    .irq_i   (irq),
    .ie_i    (int_en),
    .ready_i (mem_ready),
    .ctl_o   (ctl),
    .req_o   (mem_req),
    .we_o    (mem_we),
    .ack_o   (irq_ack),
    .phase_o (cyc_phase)
  );

  icc_datapath #(
    .ADDR_W    (ADDR_W),
    .SAVE_ADDR (SAVE_ADDR),
    .VEC_ADDR  (VEC_ADDR)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_i   (ctl),
    .rdata_i (mem_rdata),
    .pc_o    (pc),
    .mar_o   (mem_addr),
    .mbr_o   (mem_wdata),
    .ir_o    (ir),
    .acc_o   (acc),
    .ie_o    (int_en)
  );

  assign xfer = {ctl.ie != IE_HOLD, ctl.ld_acc, ctl.pc != PC_HOLD,
                 ctl.ld_ir, ctl.mbr != MBR_HOLD, ctl.mar != MAR_HOLD};

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata)));

  p_fetch_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && cyc_phase[0]) |=> (pc == $past(mem_addr) + 1'b1));

  p_ie_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !int_en);

endmodule

// File: tb/icc_seq_test.sv
module icc_seq_test;
  localparam int AW = 8;
  localparam int DW = 12;
  localparam logic [AW-1:0] SAVE = 8'hFE;
  localparam logic [AW-1:0] VEC  = 8'hFF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, irq = 1'b0, mem_ready = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic irq_ack, int_en, mem_req, mem_we;
  logic [AW-1:0] mem_addr, pc;
  logic [DW-1:0] mem_wdata, acc, ir;
  logic [3:0] cyc_phase;
  logic [5:0] xfer;

  icc_seq uut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .irq_ack(irq_ack), .int_en(int_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .pc(pc), .acc(acc), .ir(ir),
    .cyc_phase(cyc_phase), .xfer(xfer)
  );

  logic [DW-1:0] mem [256];
  int wait_cfg = 0, cnt = 0;
  logic lat_we; logic [AW-1:0] lat_addr; logic [DW-1:0] lat_dat;
  logic tr_we [64]; logic [AW-1:0] tr_addr [64]; logic [DW-1:0] tr_dat [64];
  int tr_n = 0, ack_n = 0, hs_bad = 0, oh_bad = 0;
  logic p_req = 0, p_rdy = 0, p_we = 0;
  logic [AW-1:0] p_addr = '0; logic [DW-1:0] p_wd = '0;
  logic e_we [64]; logic [AW-1:0] e_addr [64]; logic [DW-1:0] e_dat [64];
  int e_n = 0;
  int n_chk = 0, n_fail = 0;

  // memory model and port monitors, all at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0; cnt = wait_cfg; tr_n = 0; ack_n = 0; p_req = 0; p_rdy = 0;
    end else begin
      if (p_req && !p_rdy &&
          (!mem_req || mem_we != p_we || mem_addr != p_addr || mem_wdata != p_wd))
        hs_bad++;
      if (!$onehot(cyc_phase)) oh_bad++;
      if (irq_ack) ack_n++;
      if (mem_ready) begin
        if (tr_n < 64) begin
          tr_we[tr_n] = lat_we; tr_addr[tr_n] = lat_addr; tr_dat[tr_n] = lat_dat; tr_n++;
        end
        if (lat_we) mem[lat_addr] = lat_dat;
        mem_ready = 1'b0; cnt = wait_cfg;
      end else if (mem_req) begin
        if (cnt == 0) begin
          mem_ready = 1'b1; mem_rdata = mem[mem_addr];
          lat_we = mem_we; lat_addr = mem_addr;
          lat_dat = mem_we ? mem_wdata : mem[mem_addr];
        end else cnt--;
      end
      p_req = mem_req; p_rdy = mem_ready; p_we = mem_we; p_addr = mem_addr; p_wd = mem_wdata;
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(bit ind, int op, logic [AW-1:0] a);
    return {ind, 3'(op), a};
  endfunction

  task automatic push(bit we, logic [AW-1:0] a, logic [DW-1:0] d);
    e_we[e_n] = we; e_addr[e_n] = a; e_dat[e_n] = d; e_n++;
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 256; k++) mem[k] = '0;
  endtask

  task automatic run_until(int n, string tag);
    int t = 0;
    while (tr_n < n && t < 600) begin @(negedge clk); t++; end
    check(tr_n >= n, tag, "access count", tr_n, n);
  endtask

  task automatic cmp_trace(string tag);
    int bad = -1;
    for (int k = 0; k < e_n; k++)
      if (bad < 0 && (k >= tr_n || tr_we[k] != e_we[k] || tr_addr[k] != e_addr[k] ||
                      (e_we[k] && tr_dat[k] != e_dat[k]))) bad = k;
    if (bad < 0) check(1'b1, tag, "trace", 0, 0);
    else check(1'b0, tag, $sformatf("trace entry %0d we/addr/data", bad),
               {tr_we[bad], tr_addr[bad], tr_dat[bad]}, {e_we[bad], e_addr[bad], e_dat[bad]});
  endtask

  task automatic run_one(int o, bit i, int w);
    logic [AW-1:0] a, p, ea, nx;
    logic [DW-1:0] d0;
    bit memref;
    string tag;
    rst_n = 1'b0; irq = 1'b0; wait_cfg = w;
    clear_mem();
    a = 8'(8'h40 + o * 4); p = 8'(8'h80 + o * 4);
    memref = (o < 3); ea = (i && memref) ? p : a; d0 = 12'h5A0 | 12'(o);
    mem[0] = mk(0, 4, 0); mem[1] = mk(0, 0, 8'h20); mem[8'h20] = d0;
    mem[2] = mk(i, o, a); mem[a] = {4'h3, p}; mem[p] = 12'(12'h700 + o); mem[SAVE] = 12'h0C0;
    nx = (o == 2) ? ea : (o == 3) ? 8'hC0 : 8'h03;
    mem[nx] = mk(0, 2, nx);
    e_n = 0;
    push(0, 0, 0); push(0, 1, 0); push(0, 8'h20, 0); push(0, 2, 0);
    if (i && memref) push(0, a, 0);
    case (o)
      0: push(0, ea, 0);
      1: push(1, ea, d0);
      3: push(0, SAVE, 0);
      default: ;
    endcase
    push(0, nx, 0);
    case (o)
      0, 1: tag = "R5";
      2: tag = "R6";
      3: tag = "R9";
      4, 5: tag = "R11";
      default: tag = "R2";
    endcase
    if (i) tag = {tag, memref ? " R4" : " R10"};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_until(e_n, tag);
    cmp_trace(tag);
    repeat (40) @(negedge clk);
    check(ir == mk(0, 2, nx), "R2", "ir after loop", ir, mk(0, 2, nx));
    if (o == 0) check(acc == (i ? 12'(12'h700 + o) : {4'h3, p}), "R5", "acc after load", acc,
                      i ? 12'(12'h700 + o) : {4'h3, p});
    if (o == 1) check(mem[ea] == d0, "R5", "stored word", mem[ea], d0);
    if (o == 4) check(int_en == 1'b1, "R11", "enable flag", int_en, 1);
    if (o == 5) check(int_en == 1'b0, "R11", "enable flag", int_en, 0);
  endtask

  task automatic run_irq(int w);
    rst_n = 1'b0; irq = 1'b1; wait_cfg = w;
    clear_mem();
    mem[0] = mk(0, 4, 0); mem[1] = mk(0, 5, 0); mem[2] = mk(0, 4, 0); mem[3] = mk(0, 2, 3);
    mem[VEC] = 12'h050; mem[8'h50] = mk(0, 3, 0);
    e_n = 0;
    push(0, 0, 0); push(1, SAVE, 12'h001); push(0, VEC, 0); push(0, 8'h50, 0);
    push(0, SAVE, 0); push(0, 1, 0); push(0, 2, 0); push(1, SAVE, 12'h003);
    push(0, VEC, 0); push(0, 8'h50, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_until(e_n, "R8");
    cmp_trace("R7 R8");
    check(ack_n == 2, "R8", "acknowledge pulses", ack_n, 2);
    check(int_en == 1'b0, "R8", "enable after entry", int_en, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    wait_cfg = 1;
    clear_mem();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(pc == '0, "R1", "pc in reset", pc, 0);
    check(acc == '0, "R1", "acc in reset", acc, 0);
    check(int_en == 1'b0, "R1", "enable in reset", int_en, 0);
    check(mem_req == 1'b0, "R1", "request in reset", mem_req, 0);
    check(cyc_phase == 4'b0001, "R1", "phase in reset", cyc_phase, 1);
    rst_n = 1'b1;
    run_until(1, "R1");
    check(tr_addr[0] == '0 && !tr_we[0], "R1", "first access", tr_addr[0], 0);
    for (int w = 0; w < 3; w++)
      for (int o = 0; o < 8; o++)
        for (int i = 0; i < 2; i++) run_one(o, i[0], w);
    run_irq(0);
    run_irq(2);
    check(hs_bad == 0, "R3", "held-request violations", hs_bad, 0);
    check(oh_bad == 0, "R12", "phase not one-hot", oh_bad, 0);
    summary();
    $finish;
  end
endmodule